// File: doc/BRIEF.md
# Program Status Register Write Unit

This unit holds a processor's current status word and one saved status word. It carries out the move-to-status operation, which merges an operand into either word under per-field enables. It also carries out the move-from-status operation, which returns a whole word. The operand comes from a register value or from an 8-bit immediate that is rotated right by twice a 4-bit rotate amount.

The current word has three writable bit groups, and the privilege level decides which of them an operation may change:
- The condition flags (bits 31:28) can be written in every mode.
- The execution-state bit (bit 5) can be written in every mode.
- The interrupt masks (bits 7:6) and the mode bits (bits 3:0) can be written only outside user mode.

Bit 4 of the mode field is always forced to 1. A one-cycle strobe marks every real mode change, so that register-bank logic elsewhere can follow it. Only one saved word is kept; banking it per mode is left to the surrounding logic.

Top module: `psr_write_unit`

## Requirements
- R1: After reset the current word is 0x000000D3 (supervisor mode 0x13, both interrupt masks set), the saved word is 0x00000010, and `modeChange` and `rdValid` are 0.
- R2: A current-word write with `flagFieldEn`=1 copies operand bits 31:28 into the current word in every mode, user mode (mode 0x10) included.
- R3: A current-word write with `ctlFieldEn`=1 outside user mode copies operand bits 7, 6, 5 and 3:0 into the current word. The new mode field becomes operand[3:0] with bit 4 set.
- R4: In user mode, a current-word write with `ctlFieldEn`=1 changes only bit 5. Bits 7:6 and 4:0 keep their values.
- R5: Bits 27:8 of the current word never change. A write with both field enables at 0 leaves the current word unchanged.
- R6: A saved-word write (`selSaved`=1) builds a field mask from the enables, with 0x000000FF for control and 0xFF000000 for flags. It ANDs that mask with 0xF00000EF, merges the operand under the result, and forces bit 4 to 1. The current word is not affected.
- R7: With `useImm`=1 the operand is the zero-extended `immValue`, rotated right by 2×`immRotate` bit positions.
- R8: `modeChange` is high for exactly the one cycle in which a write's new current mode field first appears, and only if that field differs from its previous value.
- R9: A read (`rdEn`=1) returns the whole current word (`selSaved`=0) or saved word (`selSaved`=1) on `rdData` in the next cycle, with `rdValid` high for that cycle.
- R10: A write takes effect on the clock edge that samples `wrEn`, so the new word is visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Execute a move-to-status write this cycle |
| rdEn | input | 1 | Execute a move-from-status read this cycle |
| selSaved | input | 1 | 0 selects the current word, 1 selects the saved word |
| ctlFieldEn | input | 1 | Control field enable (bits 7:0) |
| flagFieldEn | input | 1 | Flags field enable (bits 31:24) |
| useImm | input | 1 | Take the operand from the rotated immediate |
| regOperand | input | 32 | Register operand |
| immValue | input | 8 | Immediate byte |
| immRotate | input | 4 | Rotate amount (doubled) for the immediate |
| curPsr | output | 32 | Current status word |
| savedPsr | output | 32 | Saved status word |
| rdData | output | 32 | Read result |
| rdValid | output | 1 | Read result valid |
| modeChange | output | 1 | One-cycle strobe on a mode change |

## Verification
Every result of this unit is due exactly one clock after the cycle that carries its request. This covers the updated current and saved words, the `modeChange` strobe, and `rdData` with `rdValid`. The driver applies one request per cycle on the falling edge and, in the same step, queues the values the outputs must show after the next rising edge. The monitor wakes one nanosecond after each rising edge, takes the oldest queued item and compares every output with it. Because queued items and clock edges stay one to one, an output that arrives a cycle early or a cycle late is reported.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W = 32;
  localparam int IMM_W = 8;
  localparam int ROT_W = 4;
  localparam int MODE_W = 5;
  localparam int AMT_W = ROT_W + 1;

  localparam logic [PSR_W-1:0] FLAG_GROUP  = 32'hF000_0000;
  localparam logic [PSR_W-1:0] PRIV_GROUP  = 32'h0000_00CF;
  localparam logic [PSR_W-1:0] STATE_GROUP = 32'h0000_0020;
  localparam logic [PSR_W-1:0] LEGAL_BITS  = FLAG_GROUP | PRIV_GROUP | STATE_GROUP;
  localparam logic [PSR_W-1:0] MODE_FORCE  = 32'h0000_0010;
  localparam logic [PSR_W-1:0] CTL_FIELD   = 32'h0000_00FF;
  localparam logic [PSR_W-1:0] FLAG_FIELD  = 32'hFF00_0000;

  localparam logic [MODE_W-1:0] MODE_USER = 5'h10;
  localparam logic [PSR_W-1:0] CUR_RESET   = 32'h0000_00D3;
  localparam logic [PSR_W-1:0] SAVED_RESET = 32'h0000_0010;

  typedef struct packed {
    logic wrFlags;
    logic wrState;
    logic wrPriv;
    logic wrSavedCtl;
    logic wrSavedFlags;
    logic wrSaved;
    logic rdCur;
    logic rdSaved;
  } psrStrobes_t;
endpackage

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              selSaved,
  input  logic              ctlFieldEn,
  input  logic              flagFieldEn,
  input  logic [MODE_W-1:0] curMode,
  output psrStrobes_t       strobes
);
  logic curWr;
  logic privOk;

  assign curWr  = wrEn && !selSaved;
  assign privOk = (curMode != MODE_USER);

  always_comb begin
    strobes              = '0;
    strobes.wrFlags      = curWr && flagFieldEn;
    strobes.wrState      = curWr && ctlFieldEn;
    strobes.wrPriv       = curWr && ctlFieldEn && privOk;
    strobes.wrSaved      = wrEn && selSaved;
    strobes.wrSavedCtl   = wrEn && selSaved && ctlFieldEn;
    strobes.wrSavedFlags = wrEn && selSaved && flagFieldEn;
    strobes.rdCur        = rdEn && !selSaved;
    strobes.rdSaved      = rdEn && selSaved;
  end

  // R4: once the current mode is user, the control must never issue a privileged write
  p_user_blocks_priv_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !selSaved && ctlFieldEn && curMode == MODE_USER) |-> !strobes.wrPriv);

  // R6: a saved-word access never raises a current-word write strobe
  p_saved_isolated_r6: assert property (@(posedge clk) disable iff (!rstN)
    selSaved |-> !(strobes.wrFlags || strobes.wrState || strobes.wrPriv || strobes.rdCur));
endmodule

// File: rtl/psr_datapath.sv
module psr_datapath
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  psrStrobes_t       strobes,
  input  logic              useImm,
  input  logic [PSR_W-1:0]  regOperand,
  input  logic [IMM_W-1:0]  immValue,
  input  logic [ROT_W-1:0]  immRotate,
  output logic [PSR_W-1:0]  curPsr,
  output logic [PSR_W-1:0]  savedPsr,
  output logic [PSR_W-1:0]  rdData,
  output logic              rdValid,
  output logic              modeChange
);
  logic [PSR_W-1:0]   immWide;
  logic [2*PSR_W-1:0] immPair;
  logic [AMT_W-1:0]   rotAmt;
  logic [PSR_W-1:0]   rotated;
  logic [PSR_W-1:0]   operand;
  logic [PSR_W-1:0]   nextCur;
  logic [PSR_W-1:0]   savedMask;
  logic [PSR_W-1:0]   nextSaved;
  logic               nextModeChange;
  logic               anyCurWr;
  logic               pastValid;

  assign immWide = {{(PSR_W-IMM_W){1'b0}}, immValue};
  assign rotAmt  = {immRotate, 1'b0};
  assign immPair = {immWide, immWide} >> rotAmt;
  assign rotated = immPair[PSR_W-1:0];
  assign operand = useImm ? rotated : regOperand;

  assign anyCurWr = strobes.wrFlags || strobes.wrState || strobes.wrPriv;

  always_comb begin
    nextCur = curPsr;
    if (strobes.wrFlags) nextCur = (nextCur & ~FLAG_GROUP) | (operand & FLAG_GROUP);
    if (strobes.wrState) nextCur = (nextCur & ~STATE_GROUP) | (operand & STATE_GROUP);
    if (strobes.wrPriv)  nextCur = (nextCur & ~PRIV_GROUP) | (operand & PRIV_GROUP) | MODE_FORCE;
    nextModeChange = strobes.wrPriv && (nextCur[MODE_W-1:0] != curPsr[MODE_W-1:0]);
  end

  always_comb begin
    savedMask = ({PSR_W{strobes.wrSavedCtl}} & CTL_FIELD) |
                ({PSR_W{strobes.wrSavedFlags}} & FLAG_FIELD);
    savedMask = savedMask & LEGAL_BITS;
    nextSaved = (savedPsr & ~savedMask) | (operand & savedMask) | MODE_FORCE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPsr     <= CUR_RESET;
      savedPsr   <= SAVED_RESET;
      rdData     <= '0;
      rdValid    <= 1'b0;
      modeChange <= 1'b0;
      pastValid  <= 1'b0;
    end else begin
      pastValid  <= 1'b1;
      curPsr     <= nextCur;
      modeChange <= nextModeChange;
      if (strobes.wrSaved) savedPsr <= nextSaved;
      rdValid <= strobes.rdCur || strobes.rdSaved;
      if (strobes.rdCur)        rdData <= curPsr;
      else if (strobes.rdSaved) rdData <= savedPsr;
    end
  end

  // R8: the strobe only accompanies a real change of the mode field
  p_strobe_real_change_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && modeChange) |-> (curPsr[MODE_W-1:0] != $past(curPsr[MODE_W-1:0])));

  // R5: with no current-word strobe the current word holds
  p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(anyCurWr)) |-> (curPsr == $past(curPsr)));

  // R4: user mode cannot be left by a status write
  p_user_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(curPsr[MODE_W-1:0]) == MODE_USER) |-> (curPsr[MODE_W-1:0] == MODE_USER));

  // R6: the saved word always keeps its forced mode bit
  p_saved_bit4_r6: assert property (@(posedge clk) disable iff (!rstN)
    savedPsr[4]);

  // R9: a valid read result follows each read request by one cycle
  p_read_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (rdValid == $past(strobes.rdCur || strobes.rdSaved)));
endmodule

// File: rtl/psr_write_unit.sv
module psr_write_unit
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              selSaved,
  input  logic              ctlFieldEn,
  input  logic              flagFieldEn,
  input  logic              useImm,
  input  logic [PSR_W-1:0]  regOperand,
  input  logic [IMM_W-1:0]  immValue,
  input  logic [ROT_W-1:0]  immRotate,
  output logic [PSR_W-1:0]  curPsr,
  output logic [PSR_W-1:0]  savedPsr,
  output logic [PSR_W-1:0]  rdData,
  output logic              rdValid,
  output logic              modeChange
);
  psrStrobes_t strobes;

  psr_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .rdEn        (rdEn),
    .selSaved    (selSaved),
    .ctlFieldEn  (ctlFieldEn),
    .flagFieldEn (flagFieldEn),
    .curMode     (curPsr[MODE_W-1:0]),
    .strobes     (strobes)
  );

  psr_datapath dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .useImm     (useImm),
    .regOperand (regOperand),
    .immValue   (immValue),
    .immRotate  (immRotate),
    .curPsr     (curPsr),
    .savedPsr   (savedPsr),
    .rdData     (rdData),
    .rdValid    (rdValid),
    .modeChange (modeChange)
  );
endmodule

// File: tb/psr_write_unit_tb.sv
module psr_write_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0, selSaved = 1'b0;
  logic        ctlFieldEn = 1'b0, flagFieldEn = 1'b0, useImm = 1'b0;
  logic [31:0] regOperand = '0;
  logic [7:0]  immValue = '0;
  logic [3:0]  immRotate = '0;
  logic [31:0] curPsr, savedPsr, rdData;
  logic        rdValid, modeChange;

  always #2.5 clk = ~clk;

  psr_write_unit dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .selSaved(selSaved),
    .ctlFieldEn(ctlFieldEn), .flagFieldEn(flagFieldEn), .useImm(useImm),
    .regOperand(regOperand), .immValue(immValue), .immRotate(immRotate),
    .curPsr(curPsr), .savedPsr(savedPsr), .rdData(rdData), .rdValid(rdValid),
    .modeChange(modeChange)
  );

  typedef struct {
    logic [31:0] cur;
    logic [31:0] saved;
    logic        mc;
    logic        rv;
    logic [31:0] rd;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  bit monitorOn = 1'b0;

  logic [31:0] mCur = 32'h0000_00D3;
  logic [31:0] mSaved = 32'h0000_0010;
  logic [31:0] mRd = '0;

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  // one request per cycle: drive at falling edge, queue what is due after the next rise
  task automatic step(string tag, bit w, bit r, bit sav, bit ctl, bit flg, bit imm,
                      logic [31:0] op, logic [7:0] iv, logic [3:0] ir);
    logic [31:0] eff;
    logic [31:0] nCur;
    logic [31:0] mask;
    bit mc;
    expItem_t it;
    @(negedge clk);
    wrEn = w; rdEn = r; selSaved = sav; ctlFieldEn = ctl; flagFieldEn = flg;
    useImm = imm; regOperand = op; immValue = iv; immRotate = ir;
    eff = op;
    if (imm) begin
      eff = {24'h0, iv};
      for (int k = 0; k < 2 * ir; k++) eff = {eff[0], eff[31:1]};
    end
    nCur = mCur;
    mc = 1'b0;
    if (r) mRd = sav ? mSaved : mCur;
    if (w && !sav) begin
      if (flg) nCur[31:28] = eff[31:28];
      if (ctl) begin
        nCur[5] = eff[5];
        if (mCur[4:0] != 5'h10) begin
          nCur[7:6] = eff[7:6];
          nCur[4:0] = {1'b1, eff[3:0]};
          mc = (nCur[4:0] != mCur[4:0]);
        end
      end
    end
    if (w && sav) begin
      mask = (ctl ? 32'h0000_00FF : 32'h0) | (flg ? 32'hFF00_0000 : 32'h0);
      mask = mask & 32'hF000_00EF;
      mSaved = (mSaved & ~mask) | (eff & mask) | 32'h10;
    end
    mCur = nCur;
    it.cur = mCur; it.saved = mSaved; it.mc = mc; it.rv = r; it.rd = mRd; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 32'h0, 8'h0, 4'h0);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (monitorOn && expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check32(e.tag, "curPsr", curPsr, e.cur);
        check32(e.tag, "savedPsr", savedPsr, e.saved);
        check32(e.tag, "modeChange", {31'h0, modeChange}, {31'h0, e.mc});
        check32(e.tag, "rdValid", {31'h0, rdValid}, {31'h0, e.rv});
        if (e.rv) check32(e.tag, "rdData", rdData, e.rd);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check32("R1", "curPsr reset", curPsr, 32'h0000_00D3);
    check32("R1", "savedPsr reset", savedPsr, 32'h0000_0010);
    check32("R1", "strobes reset", {30'h0, modeChange, rdValid}, 32'h0);
    monitorOn = 1'b1;
    // R3 R8 R10: privileged control write to system mode
    step("R3", 1, 0, 0, 1, 0, 0, 32'h0000_001F, 8'h0, 4'h0);
    // R8: same mode again, no strobe
    step("R8", 1, 0, 0, 1, 0, 0, 32'h0000_001F, 8'h0, 4'h0);
    idle("R10");
    // R2 R5: flags only, bits 27:8 of operand ignored
    step("R2", 1, 0, 0, 0, 1, 0, 32'hA5FF_FFFF, 8'h0, 4'h0);
    // R3 R5: both fields
    step("R3", 1, 0, 0, 1, 1, 0, 32'h5FFF_FFE2, 8'h0, 4'h0);
    // R5: no field enabled
    step("R5", 1, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 8'h0, 4'h0);
    // R6: saved writes
    step("R6", 1, 0, 1, 1, 1, 0, 32'hFFFF_FFFF, 8'h0, 4'h0);
    step("R6", 1, 0, 1, 0, 1, 0, 32'h0000_0000, 8'h0, 4'h0);
    step("R6", 1, 0, 1, 1, 0, 0, 32'h0000_0000, 8'h0, 4'h0);
    // R7: immediate, enter user mode
    step("R7", 1, 0, 0, 1, 0, 1, 32'hFFFF_FFFF, 8'h10, 4'h0);
    // R7 R2: rotated immediate into flags while in user mode
    step("R7", 1, 0, 0, 0, 1, 1, 32'h0, 8'hC0, 4'h4);
    // R4: user mode control write touches only bit 5
    step("R4", 1, 0, 0, 1, 0, 0, 32'h0000_00FF, 8'h0, 4'h0);
    step("R4", 1, 0, 0, 1, 0, 0, 32'h0000_00C3, 8'h0, 4'h0);
    // R7: odd rotate wraps low bits to the top
    step("R7", 1, 0, 0, 1, 1, 1, 32'h0, 8'h05, 4'h1);
    // R9: reads of both words
    step("R9", 0, 1, 0, 0, 0, 0, 32'h0, 8'h0, 4'h0);
    step("R9", 0, 1, 1, 0, 0, 0, 32'h0, 8'h0, 4'h0);
    idle("R9");
    idle("R5");
    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule